// File: doc/BRIEF.md
# Segment Address Extension Unit

This unit sits on a slave port of a shared memory controller and widens 32-bit logical bus addresses into 36-bit physical addresses. Every master privilege ID owns a private bank of eight programmable segments. A segment names a logical base, a power-of-two size, a replacement physical base and read, write and fetch permissions. The unit checks each request against the segments of its privilege ID and applies the highest-numbered match. If no segment applies, the request either passes through untranslated or returns an addressing error.

Segment registers sit in a small register space. They take effect for requests issued on the cycle after the write. Translation is combinational, and a single register stage holds the response. A segment whose result lands in external memory (physical bit 35 set) is honoured only when the logical address lies in the upper half of the 32-bit space. For a lower logical address, such a segment is skipped, and a lower-priority segment or the untranslated path decides the access.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset, segment 0 of every privilege ID has map word 0x8000_0007 and window word 0x8000_001E, so it maps logical 0x8000_0000..0xFFFF_FFFF to physical 0x8_0000_0000 with all permissions. Every other segment reads as zero.
- R2: Segment k of privilege n has its map word at byte offset 0x600 + 64*n + 8*k and its window word 4 bytes higher. The map word holds physical base bits [35:12] in bits [31:8], and fetch, write and read permissions in bits 2, 1 and 0. The window word holds logical base bits [31:12] in bits [31:12] and the size code in bits [4:0]. All other bits read as zero.
- R3: A size code c covers 2^(c+1) bytes, and codes 1..10 behave as 4 KB. Only the logical address bits above the size are compared with the base. The physical base supplies the bits above the size, and the lower bits pass through from the logical address.
- R4: A segment with size code 0 never matches.
- R5: When several segments apply, the highest-numbered one decides the result.
- R6: A segment whose result has physical bit 35 set is skipped for logical addresses below 0x8000_0000.
- R7: When no segment applies, the result depends on the logical address. An address at or above 0x8000_0000, or inside the 4 KB register window at 0x0BC0_0000, passes through with physical bits [35:32] zero. Any other address returns an error.
- R8: The deciding segment must grant the needed permission: fetch needs bit 2, a write needs bit 1 and a read needs bit 0. Without it the response is an error. Every error response carries a zero physical address.
- R9: The response appears exactly one cycle after the request, and rsp_valid is low otherwise. A request issued on the cycle of a register write still sees the old table.
- R10: A request uses only the segments of its own privilege ID.
- R11: Register offsets outside the segment table read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_priv | input | 4 | Privilege ID of the requesting master |
| req_addr | input | 32 | Logical address |
| req_write | input | 1 | Request is a write |
| req_fetch | input | 1 | Request is an instruction fetch (takes precedence over write) |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Addressing or permission error |
| rsp_paddr | output | 36 | Physical address, zero on error |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |

## Verification
A corrupted table entry or a wrong priority decision shows up in rsp_paddr or rsp_err on the very next cycle after a request that touches the affected segment. It also appears on reg_rdata as soon as that offset is addressed. A bad window compare or merge mask shows up only for addresses near segment edges, so the random requests are clustered around the programmed bases. Both priority and the low-address skip are exercised by stacking overlapping segments.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef struct packed {
    logic [19:0] lbase;
    logic [4:0]  size;
    logic [23:0] pbase;
    logic        ex;
    logic        wr;
    logic        rd;
  } seg_t;

  localparam seg_t SEG_EMPTY = '0;
  localparam seg_t SEG_BOOT  = '{lbase: 20'h80000, size: 5'd30, pbase: 24'h800000,
                                 ex: 1'b1, wr: 1'b1, rd: 1'b1};

  // number of low address bits that pass through a segment
  function automatic logic [5:0] span_bits(input logic [4:0] code);
    return (code < 5'd11) ? 6'd12 : ({1'b0, code} + 6'd1);
  endfunction

  function automatic logic [35:0] span_mask(input logic [4:0] code);
    logic [36:0] one;
    one = 37'd1 << span_bits(code);
    return 36'(one - 37'd1);
  endfunction

  function automatic logic seg_covers(input seg_t s, input logic [31:0] a);
    logic [35:0] m;
    m = span_mask(s.size);
    return (s.size != 5'd0) &&
           ((({4'b0, a} ^ {4'b0, s.lbase, 12'h000}) & ~m) == 36'd0);
  endfunction

  function automatic logic [35:0] seg_target(input seg_t s, input logic [31:0] a);
    logic [35:0] m;
    m = span_mask(s.size);
    return ({s.pbase, 12'h000} & ~m) | ({4'b0, a} & m);
  endfunction

endpackage

// File: rtl/seg_table.sv
module seg_table
  import seg_xlate_pkg::*;
#(
  parameter int NUM_PRIV = 16,
  parameter int NUM_SEG  = 8,
  parameter int REG_AW   = 12,
  parameter logic [REG_AW-1:0] TABLE_BASE = 12'h600
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         reg_wr,
  input  logic [REG_AW-1:0]            reg_addr,
  input  logic [31:0]                  reg_wdata,
  output logic [31:0]                  reg_rdata,
  input  logic [$clog2(NUM_PRIV)-1:0]  sel_priv,
  output seg_t [NUM_SEG-1:0]           priv_segs
);
  localparam int PRIV_W     = $clog2(NUM_PRIV);
  localparam int SEG_W      = $clog2(NUM_SEG);
  localparam int BLK_BYTES  = NUM_SEG * 8;
  localparam int TABLE_SPAN = NUM_PRIV * BLK_BYTES;

  seg_t tbl [NUM_PRIV][NUM_SEG];

  logic [REG_AW-1:0] off;
  logic              in_tbl;
  logic              dec_word;
  logic [SEG_W-1:0]  dec_seg;
  logic [PRIV_W-1:0] dec_priv;
  logic              unused_bits;

  assign off      = reg_addr - TABLE_BASE;
  assign in_tbl   = (reg_addr >= TABLE_BASE) && (off < REG_AW'(TABLE_SPAN));
  assign dec_word = off[2];
  assign dec_seg  = off[3 +: SEG_W];
  assign dec_priv = off[3+SEG_W +: PRIV_W];
  assign unused_bits = ^{reg_wdata[7:5], off[1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NUM_PRIV; p++)
        for (int k = 0; k < NUM_SEG; k++)
          tbl[p][k] <= (k == 0) ? SEG_BOOT : SEG_EMPTY;
    end else if (reg_wr && in_tbl) begin
      if (dec_word) begin
        tbl[dec_priv][dec_seg].lbase <= reg_wdata[31:12];
        tbl[dec_priv][dec_seg].size  <= reg_wdata[4:0];
      end else begin
        tbl[dec_priv][dec_seg].pbase <= reg_wdata[31:8];
        tbl[dec_priv][dec_seg].ex    <= reg_wdata[2];
        tbl[dec_priv][dec_seg].wr    <= reg_wdata[1];
        tbl[dec_priv][dec_seg].rd    <= reg_wdata[0];
      end
    end
  end

  always_comb begin
    seg_t s;
    s = tbl[dec_priv][dec_seg];
    reg_rdata = 32'd0;
    if (in_tbl)
      reg_rdata = dec_word ? {s.lbase, 7'd0, s.size} : {s.pbase, 5'd0, s.ex, s.wr, s.rd};
  end

  always_comb
    for (int k = 0; k < NUM_SEG; k++) priv_segs[k] = tbl[sel_priv][k];

  // R2
  wr_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && in_tbl && dec_word) |=>
      (!$stable(reg_addr) || reg_rdata[4:0] == $past(reg_wdata[4:0])));

endmodule

// File: rtl/seg_match.sv
module seg_match
  import seg_xlate_pkg::*;
#(
  parameter int NUM_SEG = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  seg_t [NUM_SEG-1:0]         segs,
  input  logic [31:0]                addr,
  input  logic                       is_write,
  input  logic                       is_fetch,
  output logic                       any_win,
  output logic [35:0]                win_paddr,
  output logic                       perm_ok
);
  localparam int SEG_W = $clog2(NUM_SEG);

  logic [NUM_SEG-1:0] hit_vec;
  logic [NUM_SEG-1:0] elig_vec;
  logic [NUM_SEG-1:0] grant;
  logic [35:0]        tgt [NUM_SEG];
  logic [SEG_W-1:0]   win_seg;

  for (genvar k = 0; k < NUM_SEG; k++) begin : g_seg
    assign hit_vec[k]  = seg_covers(segs[k], addr);
    assign tgt[k]      = seg_target(segs[k], addr);
    assign elig_vec[k] = hit_vec[k] && !(tgt[k][35] && !addr[31]);
    if (k == NUM_SEG - 1) begin : g_top
      assign grant[k] = elig_vec[k];
    end else begin : g_low
      assign grant[k] = elig_vec[k] && !(|elig_vec[NUM_SEG-1:k+1]);
    end
  end

  always_comb begin
    any_win = 1'b0;
    win_seg = '0;
    for (int k = 0; k < NUM_SEG; k++)
      if (elig_vec[k]) begin
        any_win = 1'b1;
        win_seg = SEG_W'(k);
      end
  end

  always_comb begin
    seg_t w;
    w = segs[win_seg];
    win_paddr = tgt[win_seg];
    perm_ok = is_fetch ? w.ex : (is_write ? w.wr : w.rd);
  end

  // R5
  single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  // R5
  top_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_win |-> grant[win_seg]);
  // R6
  low_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (any_win && !addr[31]) |-> !win_paddr[35]);

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import seg_xlate_pkg::*;
#(
  parameter int NUM_PRIV = 16,
  parameter int NUM_SEG  = 8,
  parameter int REG_AW   = 12,
  parameter logic [31:0] REG_WIN_BASE = 32'h0BC0_0000,
  parameter int REG_WIN_BITS = 12
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  input  logic [$clog2(NUM_PRIV)-1:0]  req_priv,
  input  logic [31:0]                  req_addr,
  input  logic                         req_write,
  input  logic                         req_fetch,
  output logic                         rsp_valid,
  output logic                         rsp_err,
  output logic [35:0]                  rsp_paddr,
  input  logic                         reg_wr,
  input  logic [REG_AW-1:0]            reg_addr,
  input  logic [31:0]                  reg_wdata,
  output logic [31:0]                  reg_rdata
);
  seg_t [NUM_SEG-1:0] cur_segs;
  logic               any_win;
  logic [35:0]        win_paddr;
  logic               perm_ok;
  logic               in_ext;
  logic               in_regs;
  logic               nxt_err;
  logic [35:0]        nxt_paddr;

  seg_table #(.NUM_PRIV(NUM_PRIV), .NUM_SEG(NUM_SEG), .REG_AW(REG_AW)) u_table (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sel_priv(req_priv), .priv_segs(cur_segs));

  seg_match #(.NUM_SEG(NUM_SEG)) u_match (
    .clk(clk), .rst_n(rst_n), .segs(cur_segs), .addr(req_addr),
    .is_write(req_write), .is_fetch(req_fetch),
    .any_win(any_win), .win_paddr(win_paddr), .perm_ok(perm_ok));

  assign in_ext  = req_addr[31];
  assign in_regs = (req_addr >> REG_WIN_BITS) == (REG_WIN_BASE >> REG_WIN_BITS);

  always_comb begin
    nxt_err   = 1'b0;
    nxt_paddr = 36'd0;
    if (any_win) begin
      if (perm_ok) nxt_paddr = win_paddr;
      else         nxt_err   = 1'b1;
    end else if (in_ext || in_regs) begin
      nxt_paddr = {4'b0, req_addr};
    end else begin
      nxt_err = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_paddr <= 36'd0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && nxt_err;
      rsp_paddr <= req_valid ? nxt_paddr : 36'd0;
    end
  end

  // R9
  rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R9
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R8
  err_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_paddr == 36'd0));

endmodule

// File: tb/seg_xlate_unit_test.sv
`timescale 1ns/1ps
module seg_xlate_unit_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0;
  logic [3:0]  req_priv = 0;
  logic [31:0] req_addr = 0;
  logic        req_write = 0;
  logic        req_fetch = 0;
  logic        rsp_valid, rsp_err;
  logic [35:0] rsp_paddr;
  logic        reg_wr = 0;
  logic [11:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] sh_map [16][8];
  logic [31:0] sh_win [16][8];

  always #2.5 clk = ~clk;

  seg_xlate_unit uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_priv(req_priv),
    .req_addr(req_addr), .req_write(req_write), .req_fetch(req_fetch),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_paddr(rsp_paddr),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  function automatic logic [11:0] seg_off(int n, int k, bit win);
    return 12'(12'h600 + 64 * n + 8 * k + (win ? 4 : 0));
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // independent reference: division-based window arithmetic
  task automatic model(input int p, input logic [31:0] a, input bit w, input bit f,
                       output bit e, output logic [35:0] pa);
    int win = -1;
    longint unsigned cand, best = 0;
    for (int k = 0; k < 8; k++) begin
      longint unsigned span, lb, pb;
      int c;
      c = int'(sh_win[p][k][4:0]);
      if (c == 0) continue;
      span = 64'd1 << ((c < 11) ? 12 : c + 1);
      lb = longint'({sh_win[p][k][31:12], 12'h000});
      pb = longint'({sh_map[p][k][31:8], 12'h000});
      if ((longint'(a) / span) != (lb / span)) continue;
      cand = (pb / span) * span + (longint'(a) % span);
      if (cand >= 64'h8_0000_0000 && a < 32'h8000_0000) continue;
      win = k; best = cand;
    end
    e = 0; pa = 0;
    if (win >= 0) begin
      bit ok;
      ok = f ? sh_map[p][win][2] : (w ? sh_map[p][win][1] : sh_map[p][win][0]);
      if (ok) pa = 36'(best); else e = 1;
    end else if (a >= 32'h8000_0000 || (a >= 32'h0BC0_0000 && a < 32'h0BC0_1000))
      pa = {4'b0, a};
    else e = 1;
  endtask

  task automatic reg_write(logic [11:0] ad, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = ad; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
    if (ad >= 12'h600 && ad < 12'hA00) begin
      int o;
      o = int'(ad) - 'h600;
      if (ad[2]) sh_win[o / 64][(o % 64) / 8] = d;
      else       sh_map[o / 64][(o % 64) / 8] = d;
    end
  endtask

  task automatic reg_check(logic [11:0] ad, logic [31:0] exp, string req);
    @(negedge clk);
    reg_addr = ad;
    #1 check(req, 64'(reg_rdata), 64'(exp));
  endtask

  task automatic req_exp(int p, logic [31:0] a, bit w, bit f, bit ee, logic [35:0] ep, string req);
    @(negedge clk);
    req_valid = 1; req_priv = 4'(p); req_addr = a; req_write = w; req_fetch = f;
    @(negedge clk);
    req_valid = 0;
    check({req, " valid"}, 64'(rsp_valid), 64'd1);
    check({req, " err"}, 64'(rsp_err), 64'(ee));
    check({req, " paddr"}, 64'(rsp_paddr), 64'(ep));
  endtask

  task automatic req_model(int p, logic [31:0] a, bit w, bit f, string req);
    bit e; logic [35:0] pa;
    model(p, a, w, f, e, pa);
    req_exp(p, a, w, f, e, pa, req);
  endtask

  initial begin
    for (int p = 0; p < 16; p++)
      for (int k = 0; k < 8; k++) begin
        sh_map[p][k] = (k == 0) ? 32'h8000_0007 : 32'h0;
        sh_win[p][k] = (k == 0) ? 32'h8000_001E : 32'h0;
      end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset contents and idle output; R9 no response without request
    reg_check(seg_off(0, 0, 0), 32'h8000_0007, "R1 seg0 map");
    reg_check(seg_off(15, 0, 1), 32'h8000_001E, "R1 seg0 window");
    reg_check(seg_off(4, 3, 1), 32'h0, "R1 other seg");
    check("R9 idle rsp_valid", 64'(rsp_valid), 64'd0);
    req_exp(3, 32'h9234_5678, 0, 0, 0, 36'h8_1234_5678, "R1 default map");
    // R7 untranslated paths
    req_exp(3, 32'h0000_1000, 0, 0, 1, 36'h0, "R7 low error");
    req_exp(3, 32'h0BC0_0010, 1, 0, 0, 36'h0_0BC0_0010, "R7 reg window");
    // R3 256 MB segment on priv 11, read+write only
    reg_write(seg_off(11, 1, 0), 32'h8000_0003);
    reg_write(seg_off(11, 1, 1), 32'hE000_001B);
    req_exp(11, 32'hE123_4567, 0, 0, 0, 36'h8_0123_4567, "R3 relocate read");
    req_exp(11, 32'hE123_4567, 1, 0, 0, 36'h8_0123_4567, "R8 write allowed");
    req_exp(11, 32'hE123_4567, 0, 1, 1, 36'h0, "R8 fetch denied");
    req_exp(10, 32'hE123_4567, 0, 0, 0, 36'h8_6123_4567, "R10 other priv");
    // R6 low logical into external memory skipped, lower segment decides
    reg_write(seg_off(11, 2, 0), 32'h0200_0007);
    reg_write(seg_off(11, 2, 1), 32'h0C00_0017);
    reg_write(seg_off(11, 3, 0), 32'h83C0_0007);
    reg_write(seg_off(11, 3, 1), 32'h0C00_0017);
    req_exp(11, 32'h0C00_0100, 0, 0, 0, 36'h0_2000_0100, "R6 skip to seg2");
    reg_write(seg_off(11, 2, 1), 32'h0C00_0000);
    req_exp(11, 32'h0C00_0100, 0, 0, 1, 36'h0, "R6 skip then error");
    // R5 priority: 4 KB seg5 overlaps seg1; R2 map bits 7:3 read zero
    reg_write(seg_off(11, 5, 0), 32'h9000_00FF);
    reg_write(seg_off(11, 5, 1), 32'hE000_000B);
    reg_check(seg_off(11, 5, 0), 32'h9000_0007, "R2 map readback");
    reg_check(seg_off(11, 5, 1), 32'hE000_000B, "R2 window readback");
    req_exp(11, 32'hE000_0ABC, 0, 1, 0, 36'h9_0000_0ABC, "R5 higher wins");
    req_exp(11, 32'hE000_1ABC, 0, 0, 0, 36'h8_0000_1ABC, "R3 outside 4KB");
    // R4 size 0 disables
    reg_write(seg_off(11, 5, 1), 32'hE000_0000);
    req_exp(11, 32'hE000_0ABC, 0, 0, 0, 36'h8_0000_0ABC, "R4 disabled seg");
    // R9 same-cycle write sees old table
    @(negedge clk);
    reg_wr = 1; reg_addr = seg_off(11, 1, 1); reg_wdata = 32'h0;
    req_valid = 1; req_priv = 4'd11; req_addr = 32'hE000_0010; req_write = 0; req_fetch = 0;
    @(negedge clk);
    reg_wr = 0; req_valid = 0; sh_win[11][1] = 32'h0;
    check("R9 old table", 64'(rsp_paddr), 64'h8_0000_0010);
    req_exp(11, 32'hE000_0010, 0, 0, 0, 36'h8_6000_0010, "R9 new table");
    // R11 unmapped offsets
    reg_write(12'h5FC, 32'hFFFF_FFFF);
    reg_write(12'hA00, 32'hFFFF_FFFF);
    reg_check(12'h5FC, 32'h0, "R11 below table");
    reg_check(12'hA00, 32'h0, "R11 above table");
    reg_check(seg_off(0, 0, 0), 32'h8000_0007, "R11 table untouched");
    req_exp(0, 32'h8000_0004, 0, 0, 0, 36'h8_0000_0004, "R11 mapping intact");
    // random mix
    void'($urandom(32'd1234));
    for (int i = 0; i < 48; i++) begin
      int p, k, c;
      logic [31:0] d;
      p = $urandom_range(15); k = $urandom_range(7);
      c = ($urandom_range(5) == 0) ? 0 : $urandom_range(31, 11);
      d = $urandom; d[11:5] = 0; d[4:0] = 5'(c);
      reg_write(seg_off(p, k, 1), d);
      reg_write(seg_off(p, k, 0), $urandom);
    end
    for (int i = 0; i < 400; i++) begin
      int p, k;
      logic [31:0] a;
      p = $urandom_range(15); k = $urandom_range(7);
      a = {sh_win[p][k][31:12], 12'h000} ^ (32'h1 << $urandom_range(31)) ^ 32'($urandom_range(4095));
      if ($urandom_range(3) == 0) a = $urandom;
      req_model(p, a, 1'($urandom), 1'($urandom_range(3) == 0), "R3 R5 R6 R7 R8 R10 random");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule